// File: doc/BRIEF.md
# Interrupt Acknowledge Daisy-Chain Responder

This block is the interrupt half of a serial controller's host bus interface. It gathers interrupt-pending flags from several fixed-priority sources belonging to two channels. While any of them may interrupt, it pulls an active-low request line low. It also takes part in a priority daisy chain: the enable comes in on `iei`, and `ieo` passes the enable on to devices of lower priority.

The host acknowledges an interrupt with an active-low acknowledge strobe followed by a single read strobe. Both strobes are sampled on the rising edge of the peripheral clock. By the time the read strobe falls, the chain has settled. If the incoming enable is then high and a request is eligible, the block latches the winning source as under service and drives an 8-bit vector for as long as the read stays low.

Software ends a service routine with a one-cycle command that retires the highest-priority source under service. The pending flags stop tracking their sources while the register pointer addresses the status or vector registers, so that a status read returns stable data.

Top module: `irq_chain_responder`

## Requirements
- R1: `ack_n` and `rd_n` pass through `SYNC_STAGES` rising-edge register stages before use. With the default of 1, a read fall driven between two edges sets the under-service state and `vec_oe` on the second rising edge after the fall, and not on the first.
- R2: On every clock the pending flags copy `src_lvl`. While `reg_ptr` equals 2 or 3 they hold their value, so a source that is raised then produces no request until the pointer moves away.
- R3: Bit 0 of `src_lvl` has the highest priority. `int_n` is low exactly when some pending source has no under-service bit set at its own index or at any lower index.
- R4: At the first sampled fall of `rd_n` while the sampled `ack_n` is low, if `iei` is high and a request is eligible, the block sets the under-service bit of the highest-priority eligible source. From that same edge it drives `vec_oe` high with `vec_out` = `VEC_BASE` (default 8'h40), and `vec_oe` returns low once `rd_n` is sampled high.
- R5: If `iei` is low when that read fall is taken, no under-service bit is set, `vec_oe` stays low and `int_n` is unchanged.
- R6: Any further read fall before `ack_n` and `rd_n` have both been sampled high again is ignored: no vector is driven and no under-service bit changes.
- R7: `ieo` is low whenever an under-service bit is set or a request is eligible. Otherwise `ieo` equals `iei`.
- R8: A one-cycle `cmd_rst_ius` pulse clears only the highest-priority under-service bit that is set. `ieo` is re-evaluated from the new state after that clock edge.
- R9: While `rst_n` is low, all pending and under-service bits are cleared, `int_n` is high and `vec_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | NSRC | Request level from each source; bit 0 has the highest priority |
| reg_ptr | input | PTR_W | Current register pointer; values 2 and 3 freeze the pending flags |
| ack_n | input | 1 | Active-low interrupt acknowledge strobe |
| rd_n | input | 1 | Active-low read strobe |
| iei | input | 1 | Daisy-chain enable in |
| ieo | output | 1 | Daisy-chain enable out |
| int_n | output | 1 | Active-low interrupt request |
| cmd_rst_ius | input | 1 | Retire the highest-priority source under service |
| vec_out | output | 8 | Interrupt vector |
| vec_oe | output | 1 | Vector drive enable |

## Verification
The hardest state to reach from the ports is two nested services at once: a low-priority source under service while a higher one is also under service. The stimulus gets there by acknowledging a low-priority source first. It then raises a higher source, which is still eligible, and acknowledges it too. After that it retires one level at a time, and `ieo` must stay low after the first retire and rise only after the second. A second read strobe inside a single acknowledge window and a read taken with the chain enable low are each driven as their own scenarios.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int unsigned VEC_W = 8;
   typedef logic [VEC_W-1:0] vec_t;
   // acknowledge window state: armed until one read has been taken
   typedef enum logic {ACKW_ARMED, ACKW_SPENT} ackw_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int STAGES  = 1,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 1 || STAGES > 4) begin : g_bad
         $error("irq_sync: STAGES must be 1..4");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= RST_VAL;
            else        chain <= d;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
   parameter int NSRC  = 6,
   parameter int PTR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  src,
   input  logic [PTR_W-1:0] ptr,
   output logic [NSRC-1:0]  ip
);
   localparam logic [PTR_W-1:0] PTR_STAT = PTR_W'(2);
   localparam logic [PTR_W-1:0] PTR_VECT = PTR_W'(3);

   generate
      if (PTR_W < 2) begin : g_bad
         $error("irq_pend: PTR_W must be at least 2");
      end
   endgenerate

   logic frozen;
   assign frozen = (ptr == PTR_STAT) || (ptr == PTR_VECT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ip <= '0;
      else if (!frozen) ip <= src;
   end

   AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(frozen) |-> (ip == $past(ip))); // R2
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int N = 6
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] first
);
   always_comb begin
      logic seen;
      seen  = 1'b0;
      first = '0;
      for (int i = 0; i < N; i++) begin
         first[i] = req[i] & ~seen;
         seen     = seen | req[i];
      end
   end
endmodule

// File: rtl/irq_chain_responder.sv
module irq_chain_responder
   import irq_pkg::*;
#(
   parameter int   NSRC        = 6,
   parameter int   PTR_W       = 4,
   parameter int   SYNC_STAGES = 1,
   parameter vec_t VEC_BASE    = 8'h40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  src_lvl,
   input  logic [PTR_W-1:0] reg_ptr,
   input  logic             ack_n,
   input  logic             rd_n,
   input  logic             iei,
   output logic             ieo,
   output logic             int_n,
   input  logic             cmd_rst_ius,
   output logic [7:0]       vec_out,
   output logic             vec_oe
);
   generate
      if (NSRC < 1 || NSRC > 32) begin : g_bad
         $error("irq_chain_responder: NSRC must be 1..32");
      end
   endgenerate

   logic ack_s, rd_s, rd_prev, rd_fall;
   logic [NSRC-1:0] ip, ius, elig, win, ius_top;
   ackw_e ackw;
   logic take;

   irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_ack (
      .clk(clk), .rst_n(rst_n), .d(ack_n), .q(ack_s));
   irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_rd (
      .clk(clk), .rst_n(rst_n), .d(rd_n), .q(rd_s));

   irq_pend #(.NSRC(NSRC), .PTR_W(PTR_W)) i_pend (
      .clk(clk), .rst_n(rst_n), .src(src_lvl), .ptr(reg_ptr), .ip(ip));

   // a source is eligible when nothing of equal or higher priority is in service
   always_comb begin
      logic blk;
      blk  = 1'b0;
      elig = '0;
      for (int i = 0; i < NSRC; i++) begin
         blk     = blk | ius[i];
         elig[i] = ip[i] & ~blk;
      end
   end

   irq_pick #(.N(NSRC)) i_pick_win (.req(elig), .first(win));
   irq_pick #(.N(NSRC)) i_pick_top (.req(ius),  .first(ius_top));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_prev <= 1'b1;
      else        rd_prev <= rd_s;
   end
   assign rd_fall = rd_prev & ~rd_s;
   assign take    = rd_fall & ~ack_s & (ackw == ACKW_ARMED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   ackw <= ACKW_ARMED;
      else if (take)                ackw <= ACKW_SPENT;
      else if (ack_s && rd_s)       ackw <= ACKW_ARMED;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ius    <= '0;
         vec_oe <= 1'b0;
      end else begin
         ius <= (ius & ~(cmd_rst_ius ? ius_top : '0)) |
                ((take && iei) ? win : '0);
         if (take && iei && (|elig)) vec_oe <= 1'b1;
         else if (rd_s)              vec_oe <= 1'b0;
      end
   end

   assign int_n   = ~(|elig);
   assign ieo     = iei & ~(|ius) & ~(|elig);
   assign vec_out = vec_oe ? VEC_BASE : 8'h00;

   AST_IUS_NEEDS_IEI: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ius & ~$past(ius))) |-> $past(iei)); // R5
   AST_IUS_ONE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ius & ~$past(ius)) <= 1); // R4
   AST_IEO_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (|ius) |-> !ieo); // R7
   AST_VEC_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      vec_oe |-> !$past(rd_s)); // R4
   AST_RETIRE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_rst_ius) |-> ($countones($past(ius) & ~ius) <= 1)); // R8
   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |-> (int_n && !vec_oe)); // R9
endmodule

// File: tb/test_irq_chain_responder.sv
module test_irq_chain_responder;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [5:0] src_lvl;
   logic [3:0] reg_ptr;
   logic       ack_n, rd_n, iei, cmd_rst_ius;
   logic       ieo, int_n, vec_oe;
   logic [7:0] vec_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_chain_responder i_irq_chain_responder (
      .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .reg_ptr(reg_ptr),
      .ack_n(ack_n), .rd_n(rd_n), .iei(iei), .ieo(ieo), .int_n(int_n),
      .cmd_rst_ius(cmd_rst_ius), .vec_out(vec_out), .vec_oe(vec_oe));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // ack low, settle, then drop read; returns after the second edge past the fall
   task automatic ack_take();
      ack_n = 1'b0;
      cyc(2);
      rd_n = 1'b0;
      cyc(2);
   endtask

   task automatic ack_end();
      rd_n  = 1'b1;
      ack_n = 1'b1;
      cyc(3);
   endtask

   task automatic retire();
      cmd_rst_ius = 1'b1;
      cyc(1);
      cmd_rst_ius = 1'b0;
   endtask

   task automatic t_reset();
      chk("R9 int_n after reset", int_n, 1);
      chk("R9 vec_oe after reset", vec_oe, 0);
      chk("R7 ieo follows iei idle", ieo, 1);
   endtask

   task automatic t_capture();
      src_lvl = 6'b001000; cyc(1);
      chk("R3 int_n on pending", int_n, 0);
      chk("R7 ieo low on pending", ieo, 0);
      src_lvl = 6'b000000; cyc(1);
      chk("R2 pending follows source", int_n, 1);
   endtask

   task automatic t_freeze();
      reg_ptr = 4'd2; src_lvl = 6'b000100; cyc(3);
      chk("R2 frozen at ptr 2", int_n, 1);
      reg_ptr = 4'd3; cyc(2);
      chk("R2 frozen at ptr 3", int_n, 1);
      reg_ptr = 4'd0; cyc(1);
      chk("R2 released", int_n, 0);
      src_lvl = 6'b000000; cyc(1);
   endtask

   task automatic t_ack_basic();
      src_lvl = 6'b001010; cyc(1);
      ack_n = 1'b0; cyc(2);
      rd_n = 1'b0; cyc(1);
      chk("R1 no action one edge after fall", vec_oe, 0);
      cyc(1);
      chk("R4 vec_oe", vec_oe, 1);
      chk("R4 vec_out", vec_out, 32'h40);
      chk("R3 lower source blocked", int_n, 1);
      chk("R7 ieo low in service", ieo, 0);
      rd_n = 1'b1; cyc(2);
      chk("R4 vec_oe drops", vec_oe, 0);
      rd_n = 1'b0; cyc(3);
      chk("R6 second read vec_oe", vec_oe, 0);
      chk("R6 second read int_n", int_n, 1);
      ack_end();
      src_lvl = 6'b001000; cyc(1);
      chk("R3 still blocked by higher service", int_n, 1);
   endtask

   task automatic t_nest();
      retire(); // clears bit 1
      chk("R8 retire frees lower source", int_n, 0);
      ack_take();
      chk("R4 vector for source 3", vec_oe, 1);
      chk("R3 int released", int_n, 1);
      ack_end();
      src_lvl = 6'b001010; cyc(1);
      chk("R3 higher source not blocked", int_n, 0);
      ack_take();
      chk("R4 nested take", vec_oe, 1);
      ack_end();
      src_lvl = 6'b000000; cyc(1);
      retire();
      chk("R8 one level retired", ieo, 0);
      retire();
      chk("R8 both levels retired", ieo, 1);
   endtask

   task automatic t_iei_low();
      src_lvl = 6'b000001; iei = 1'b0; cyc(1);
      chk("R7 ieo low when iei low", ieo, 0);
      ack_take();
      chk("R5 no vector with iei low", vec_oe, 0);
      chk("R5 request remains", int_n, 0);
      ack_end();
      iei = 1'b1; cyc(1);
      chk("R5 no service latched", ieo, 0);
      src_lvl = 6'b000000; cyc(1);
      chk("R7 ieo follows iei", ieo, 1);
   endtask

   task automatic t_hwreset();
      src_lvl = 6'b000100; cyc(1);
      ack_take();
      rd_n = 1'b1; ack_n = 1'b1;
      src_lvl = 6'b000000; cyc(3);
      chk("R7 ieo low before reset", ieo, 0);
      rst_n = 1'b0; cyc(1);
      chk("R9 int_n in reset", int_n, 1);
      chk("R9 service cleared", ieo, 1);
      chk("R9 vec_oe in reset", vec_oe, 0);
      rst_n = 1'b1; cyc(1);
   endtask

   initial begin
      rst_n = 1'b0; src_lvl = '0; reg_ptr = '0; ack_n = 1'b1; rd_n = 1'b1;
      iei = 1'b1; cmd_rst_ius = 1'b0;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_capture();
      t_freeze();
      t_ack_basic();
      t_nest();
      t_iei_low();
      t_hwreset();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule